// File: doc/BRIEF.md
# Paged GPIO Port Controller

A byte-wide general-purpose I/O port that lives on a special-function-register bus. It keeps a port data latch and a per-pin output-mode register. From these two registers it works out, for every pin, an output value and an output enable. A pin set to push-pull always drives the latch bit. A pin set to open-drain drives only a low and releases the pad on a one. The block also sends the pad a weak pull-up enable, which a single global disable input turns off.

Register traffic reaches the block only while the externally held page select equals the block's page number. A plain read of the data register returns the pin levels after a two-flop synchronizer. A read that carries the read-modify-write strobe returns the latch instead, so that instructions which change single bits write back what was driven and not what the wire shows. A parameterised pin mask builds a reduced port in which only the top three bit positions exist.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the data latch holds 1 in every implemented bit, the mode register is 0, every pin_oe bit is 0, pin_out equals the implemented-bit mask, pu_en equals the mask and rd_data is 0.
- R2: Register reads and writes take effect only when page_sel equals PAGE_ID (default 0x0F). With any other page, writes leave the latch and mode unchanged and reads leave rd_data unchanged.
- R3: A write at DATA_ADDR (default 0x84) with a matching page loads the implemented bits of wr_data into the latch at that clock edge, and pin_out shows the latch value.
- R4: A read at DATA_ADDR with rd_rmw low updates rd_data at the read edge with pin_in as sampled two edges earlier (two-flop synchronizer), masked to the implemented bits.
- R5: A read at DATA_ADDR with rd_rmw high updates rd_data with the latch contents instead of the pin levels.
- R6: A pin whose mode bit is 1 (push-pull) has pin_oe 1 and pin_out equal to its latch bit.
- R7: A pin whose mode bit is 0 (open-drain) has pin_oe 1 with pin_out 0 when its latch bit is 0, and pin_oe 0 when its latch bit is 1. That state is the digital-input setting.
- R8: The mode register is written and read at MODE_ADDR (default 0x9C), and bit i set to 1 selects push-pull for pin i.
- R9: pu_en equals the implemented-bit mask one edge after pu_disable is 0, and is all zero one edge after pu_disable is 1.
- R10: With PIN_MASK = 0xE0 only bits 7..5 exist. The other bit positions read back as 0, ignore writes, and keep pin_oe, pin_out and pu_en at 0.
- R11: When a read and a data write both hit in the same cycle, rd_data returns the latch value from before the write and the latch takes the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_sel | input | PAGE_W | Current register page selection |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_rmw | input | 1 | Marks a read as the read phase of a read-modify-write |
| rd_data | output | W | Registered read data |
| pu_disable | input | 1 | Global weak pull-up disable |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Pad output values |
| pin_oe | output | W | Pad output enables |
| pu_en | output | W | Weak pull-up enables to the pads |

## Verification
The read path and the data write can fall in the same cycle, which is the write-back phase of a read-modify-write overlapping the next read. The bench provokes this by asserting rd_en with rd_rmw and wr_en at DATA_ADDR together. It expects rd_data to carry the old latch value while pin_out changes to the new data at that same edge. A second overlap comes from moving pin_in while the latch drives the opposite value. The bench then requires a plain read to show the pins and a read-modify-write read to show the latch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_MODE = 2'd2
  } acc_t;

  function automatic acc_t decode_acc(input logic strobe, input logic page_hit,
                                      input logic is_data, input logic is_mode);
    acc_t r;
    r = ACC_IDLE;
    if (strobe && page_hit) begin
      if (is_data)      r = ACC_DATA;
      else if (is_mode) r = ACC_MODE;
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int           W        = 8,
  parameter logic [W-1:0] PIN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_data,
  input  logic         ld_mode,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= PIN_MASK;
      mode_q  <= '0;
    end else begin
      if (ld_data) latch_q <= wdata & PIN_MASK;
      if (ld_mode) mode_q  <= wdata & PIN_MASK;
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int           W        = 8,
  parameter logic [W-1:0] PIN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] mode_q,
  input  logic         pu_disable,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pu_en
);
  logic [W-1:0] pu_q;

  always_ff @(posedge clk) begin
    if (rst)             pu_q <= PIN_MASK;
    else if (pu_disable) pu_q <= '0;
    else                 pu_q <= PIN_MASK;
  end

  // push-pull drives always; open-drain drives only a low
  assign pin_oe  = PIN_MASK & (mode_q | ~latch_q);
  assign pin_out = latch_q & PIN_MASK;
  assign pu_en   = pu_q;
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int           W        = 8,
  parameter logic [W-1:0] PIN_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  gpio_port_pkg::acc_t rd_acc,
  input  logic              rmw,
  input  logic [W-1:0]      pins_sync,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      mode_q,
  output logic [W-1:0]      rd_data
);
  import gpio_port_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_acc)
        ACC_DATA: rd_data <= rmw ? latch_q : (pins_sync & PIN_MASK);
        ACC_MODE: rd_data <= mode_q;
        default:  rd_data <= rd_data;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter int                W           = 8,
  parameter int                PAGE_W      = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [PAGE_W-1:0] PAGE_ID     = 8'h0F,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h84,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'h9C,
  parameter logic [W-1:0]      PIN_MASK    = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic              rd_rmw,
  output logic [W-1:0]      rd_data,
  input  logic              pu_disable,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pu_en
);
  import gpio_port_pkg::*;

  logic   page_hit, is_data, is_mode;
  acc_t   wr_acc, rd_acc;
  logic [W-1:0] latch_q, mode_q, pins_sync;

  assign page_hit = (page_sel == PAGE_ID);
  assign is_data  = (addr == DATA_ADDR);
  assign is_mode  = (addr == MODE_ADDR);
  assign wr_acc   = decode_acc(wr_en, page_hit, is_data, is_mode);
  assign rd_acc   = decode_acc(rd_en, page_hit, is_data, is_mode);

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  gpio_port_regs #(.W(W), .PIN_MASK(PIN_MASK)) u_regs (
    .clk(clk), .rst(rst),
    .ld_data(wr_acc == ACC_DATA), .ld_mode(wr_acc == ACC_MODE),
    .wdata(wr_data), .latch_q(latch_q), .mode_q(mode_q)
  );

  gpio_pad_drive #(.W(W), .PIN_MASK(PIN_MASK)) u_drive (
    .clk(clk), .rst(rst), .latch_q(latch_q), .mode_q(mode_q),
    .pu_disable(pu_disable), .pin_out(pin_out), .pin_oe(pin_oe), .pu_en(pu_en)
  );

  gpio_read_mux #(.W(W), .PIN_MASK(PIN_MASK)) u_rd (
    .clk(clk), .rst(rst), .rd_acc(rd_acc), .rmw(rd_rmw),
    .pins_sync(pins_sync), .latch_q(latch_q), .mode_q(mode_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int                W         = 8,
  parameter int                PAGE_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [PAGE_W-1:0] PAGE_ID   = 8'h0F,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h84,
  parameter logic [W-1:0]      PIN_MASK  = '1
) (
  input logic              clk,
  input logic              rst,
  input logic [PAGE_W-1:0] page_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [W-1:0]      wr_data,
  input logic              rd_en,
  input logic              rd_rmw,
  input logic [W-1:0]      rd_data,
  input logic              pu_disable,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pu_en
);
  logic hit, wr_dat, rd_rmw_dat;
  assign hit        = (page_sel == PAGE_ID);
  assign wr_dat     = wr_en && hit && (addr == DATA_ADDR);
  assign rd_rmw_dat = rd_en && rd_rmw && hit && (addr == DATA_ADDR);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == PIN_MASK && pu_en == PIN_MASK && rd_data == '0));

  assert_page_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_data_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (pin_out == ($past(wr_data) & PIN_MASK)));

  assert_rmw_latch_R5: assert property (@(posedge clk) disable iff (rst)
    rd_rmw_dat |=> (rd_data == $past(pin_out)));

  assert_pu_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pu_disable)) |-> (pu_en == '0));

  assert_pu_on_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pu_disable)) |-> (pu_en == PIN_MASK));

  assert_absent_bits_R10: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe | pin_out | pu_en | rd_data) & ~PIN_MASK) == '0);

  assert_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_rmw_dat && wr_dat) |=> (rd_data == $past(pin_out) &&
                                pin_out == ($past(wr_data) & PIN_MASK)));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
  .W(W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .PAGE_ID(PAGE_ID),
  .DATA_ADDR(DATA_ADDR), .PIN_MASK(PIN_MASK)
) u_chk (
  .clk(clk), .rst(rst), .page_sel(page_sel), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_rmw(rd_rmw), .rd_data(rd_data),
  .pu_disable(pu_disable), .pin_out(pin_out), .pin_oe(pin_oe), .pu_en(pu_en)
);

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PG = 8'h0F, A_DAT = 8'h84, A_MOD = 8'h9C;

  logic clk = 0, rst = 1;
  logic [7:0] page_sel = PG, addr = 0, wr_data = 0, pin_in = 0;
  logic wr_en = 0, rd_en = 0, rd_rmw = 0, pu_disable = 0;
  logic [7:0] rdata [2], pout [2], poe [2], pue [2];

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl dut (
    .clk(clk), .rst(rst), .page_sel(page_sel), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_rmw(rd_rmw), .rd_data(rdata[0]),
    .pu_disable(pu_disable), .pin_in(pin_in), .pin_out(pout[0]),
    .pin_oe(poe[0]), .pu_en(pue[0])
  );

  gpio_port_ctl #(.PIN_MASK(8'hE0)) dut_small (
    .clk(clk), .rst(rst), .page_sel(page_sel), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_rmw(rd_rmw), .rd_data(rdata[1]),
    .pu_disable(pu_disable), .pin_in(pin_in), .pin_out(pout[1]),
    .pin_oe(poe[1]), .pu_en(pue[1])
  );

  // behavioural reference state
  logic [7:0] msk [2] = '{8'hFF, 8'hE0};
  logic [7:0] m_lat [2], m_mod [2], m_rd [2], m_pu [2];
  logic [7:0] hist [$];

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 2; k++) begin
      logic [7:0] eoe;
      eoe = msk[k] & (m_mod[k] | ~m_lat[k]);
      check(pout[k] === m_lat[k], "R3 pin_out", pout[k], m_lat[k]);
      check(poe[k]  === eoe,      "R6 R7 pin_oe", poe[k], eoe);
      check(rdata[k] === m_rd[k], "R4 R5 rd_data", rdata[k], m_rd[k]);
      check(pue[k]  === m_pu[k],  "R9 pu_en", pue[k], m_pu[k]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_lat[k] = msk[k]; m_mod[k] = 0; m_rd[k] = 0; m_pu[k] = msk[k];
      end
      hist = '{8'h00, 8'h00};
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit h;
        h = (page_sel == PG);
        if (rd_en && h && addr == A_DAT) m_rd[k] = rd_rmw ? m_lat[k] : (hist[0] & msk[k]);
        else if (rd_en && h && addr == A_MOD) m_rd[k] = m_mod[k];
        if (wr_en && h && addr == A_DAT) m_lat[k] = wr_data & msk[k];
        if (wr_en && h && addr == A_MOD) m_mod[k] = wr_data & msk[k];
        m_pu[k] = pu_disable ? 8'h00 : msk[k];
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; rd_rmw = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1; step(); idle();
  endtask

  task automatic rd(input logic [7:0] a, input bit rmw);
    addr = a; rd_en = 1; rd_rmw = rmw; step(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(poe[0] == 8'h00 && pout[0] == 8'hFF, "R1 full oe/out", poe[0], 8'h00);
    check(pue[1] == 8'hE0 && pout[1] == 8'hE0, "R1 small pu/out", pue[1], 8'hE0);
    step();

    // R3 R7 open-drain after data write
    wr(A_DAT, 8'h5A);
    check(poe[0] == 8'hA5, "R7 open-drain oe", poe[0], 8'hA5);
    check(pout[1] == 8'h40, "R10 small latch masked", pout[1], 8'h40);

    // R8 R6 push-pull on upper nibble
    wr(A_MOD, 8'hF0);
    check(poe[0] == 8'hF5, "R6 push-pull oe", poe[0], 8'hF5);
    rd(A_MOD, 0);
    check(rdata[0] == 8'hF0, "R8 mode readback", rdata[0], 8'hF0);
    check(rdata[1] == 8'hE0, "R10 small mode readback", rdata[1], 8'hE0);

    // R2 page miss
    page_sel = 8'h0E;
    wr(A_DAT, 8'h00);
    check(pout[0] == 8'h5A, "R2 write ignored", pout[0], 8'h5A);
    rd(A_DAT, 1);
    check(rdata[0] == 8'hF0, "R2 read ignored", rdata[0], 8'hF0);
    page_sel = PG;

    // R4 synchronizer latency
    pin_in = 8'h3C;
    rd(A_DAT, 0);
    check(rdata[0] == 8'h00, "R4 one edge too early", rdata[0], 8'h00);
    step();
    rd(A_DAT, 0);
    check(rdata[0] == 8'h3C, "R4 pin level read", rdata[0], 8'h3C);
    check(rdata[1] == 8'h20, "R10 small pin read", rdata[1], 8'h20);

    // R5 rmw read shows latch
    rd(A_DAT, 1);
    check(rdata[0] == 8'h5A, "R5 rmw latch read", rdata[0], 8'h5A);

    // R11 overlap
    addr = A_DAT; rd_en = 1; rd_rmw = 1; wr_en = 1; wr_data = 8'hC3;
    step(); idle();
    check(rdata[0] == 8'h5A, "R11 old latch read", rdata[0], 8'h5A);
    check(pout[0] == 8'hC3, "R11 new latch", pout[0], 8'hC3);

    // R9 pull-up disable
    pu_disable = 1; step();
    check(pue[0] == 8'h00, "R9 pull-ups off", pue[0], 8'h00);
    pu_disable = 0; step();
    check(pue[1] == 8'hE0, "R9 pull-ups on", pue[1], 8'hE0);

    // R10 write all ones, then release pins as inputs
    wr(A_MOD, 8'h00);
    wr(A_DAT, 8'hFF);
    check(poe[1] == 8'h00 && pout[1] == 8'hE0, "R10 small inputs", poe[1], 8'h00);
    pin_in = 8'h95; step(); step();
    rd(A_DAT, 0);
    check(rdata[1] == 8'h80, "R10 small masked pins", rdata[1], 8'h80);
    check(rdata[0] == 8'h95, "R4 full pins", rdata[0], 8'h95);

    for (int i = 0; i < 8; i++) step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule